// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a transfer request into a table of scatter-gather descriptors for a bus-mastering DMA engine. A request gives a byte offset inside the first page and a total byte count. The block then asks a page lookup interface for one physical frame address per page the transfer touches. It builds descriptors as the frames arrive and writes each finished descriptor through a plain word-write port.

Each descriptor takes two 32-bit words. The first word is the physical base address. The second word holds a 16-bit byte count and an end-of-table flag. Pages whose frames follow on physically are folded into the descriptor that is still open. This happens only while the folded region stays inside one 64 KiB aligned address window. When the table is complete, or when the request fails, a one-cycle done pulse reports the number of descriptors written and an error flag.

Top module: `sgtBuilder`

## Requirements
- R1: The first descriptor's base is the first frame address plus the start offset, and its count is the smaller of (PAGE_SIZE minus offset) and the total length.
- R2: Each later page adds the smaller of PAGE_SIZE and the remaining byte count. When the request succeeds, exactly one page lookup handshake (pageReq and pageAck both high) takes place for each page the transfer spans.
- R3: A page is merged into the open descriptor only if two conditions hold. Its frame must equal the open base plus the open count. The last byte of the merged region must have the same address bits 31:16 as the open base.
- R4: A page that cannot be merged closes the open descriptor, and that descriptor is written out. A new descriptor then starts at the page's frame address, with the page's byte count.
- R5: The count word carries the byte count in bits 15:0 and zeros in bits 30:16. Bit 31 is the end flag: it is 1 only on the final descriptor of a successful table, and the done pulse follows the cycle after that word is written.
- R6: A descriptor that covers 65536 bytes stores 0 in bits 15:0.
- R7: Descriptor k is written as two words. The base goes to word address 2k, then the count word goes to 2k+1 in the next cycle.
- R8: The table may hold at most MAX_ENT = XFER_MAX_BYTES/PAGE_SIZE+1 descriptors (33 by default). A request that needs more ends with doneErr=1 and entryCount=MAX_ENT, and no descriptor carries the end flag.
- R9: A request with zero length makes no page lookup and no write. Its done pulse comes in the cycle after the start, with doneErr=1 and entryCount=0.
- R10: doneP is a single-cycle pulse, raised once per accepted request. At that pulse, entryCount equals the number of descriptors written, and doneErr is 0 on success.
- R11: A startReq that arrives while a request is in progress is ignored.
- R12: After reset, and while idle, the block drives no page request, no write and no done pulse, and entryCount is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse, sampled while idle |
| startOffset | input | OFF_W (12) | Byte offset of the first byte within its page |
| totalLen | input | LEN_W (32) | Total byte count of the transfer |
| pageReq | output | 1 | Requests the frame address of the next page |
| pageAck | input | 1 | Lookup answer valid; completes the handshake |
| pageAddr | input | 32 | Physical frame address of the requested page |
| memWe | output | 1 | Table word write strobe |
| memAddr | output | WADDR_W (7) | Table word address |
| memData | output | 32 | Table word data |
| doneP | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | Error flag, valid with doneP |
| entryCount | output | ENT_W (6) | Number of descriptors written |

## Verification
The hardest case to reach from the ports is the descriptor cap. It needs a request whose pages never merge and that spans one page more than the table can hold. The stimulus gives every page a frame two pages apart from the previous one and asks for 34 pages, then asks for exactly 33. This shows both the error and the largest table that still succeeds. The 64 KiB window split is reached with contiguous frames that start just below a window edge, and with a non-zero offset that pushes a 64 KiB request across the edge. Lookup answers are stalled in a pseudo-random pattern so that the merge decisions never depend on the page arrival timing.

// File: rtl/sgt_pkg.sv
package sgt_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic takePage;
    logic emitBase;
    logic emitCnt;
    logic promote;
  } sgtCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic firstPage;
    logic lastChunk;
    logic mergeOk;
    logic remZero;
    logic pendValid;
    logic capHit;
  } sgtStat_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WBASE,
    ST_WCNT
  } sgtState_t;

endpackage

// File: rtl/sgtPath.sv
module sgtPath
  import sgt_pkg::*;
#(
  parameter int PAGE_SIZE = 4096,
  parameter int LEN_W     = 32,
  parameter int OFF_W     = 12,
  parameter int MAX_ENT   = 33,
  parameter int ENT_W     = 6,
  parameter int WADDR_W   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  sgtCtl_t            ctl,
  input  logic [OFF_W-1:0]   startOffset,
  input  logic [LEN_W-1:0]   totalLen,
  input  logic [31:0]        pageAddr,
  output sgtStat_t           stat,
  output logic [WADDR_W-1:0] memAddr,
  output logic [31:0]        memData,
  output logic [ENT_W-1:0]   entryCount
);

  localparam int WIN_BITS = 16;
  localparam int CNT_W    = WIN_BITS + 1;

  logic [OFF_W-1:0] offReg;
  logic [LEN_W-1:0] remReg;
  logic             firstReg;
  logic [31:0]      openBase;
  logic [CNT_W-1:0] openCnt;
  logic [31:0]      pendBase;
  logic [CNT_W-1:0] pendCnt;
  logic             pendValid;
  logic [ENT_W-1:0] entCnt;

  logic [LEN_W-1:0] chunkLim;
  logic [LEN_W-1:0] chunkFull;
  logic [CNT_W-1:0] chunk;
  logic [31:0]      contigAddr;
  logic [31:0]      endAddr;
  logic             contig;
  logic             sameWin;

  // byte count the incoming page contributes
  always_comb begin
    chunkLim  = firstReg ? (LEN_W'(PAGE_SIZE) - LEN_W'(offReg)) : LEN_W'(PAGE_SIZE);
    chunkFull = (remReg < chunkLim) ? remReg : chunkLim;
    chunk     = chunkFull[CNT_W-1:0];
  end

  // merge test: physically adjacent and inside the open window
  always_comb begin
    contigAddr = openBase + 32'(openCnt);
    endAddr    = pageAddr + 32'(chunk) - 32'd1;
    contig     = (contigAddr == pageAddr);
    sameWin    = (endAddr[31:WIN_BITS] == openBase[31:WIN_BITS]);
  end

  always_comb begin
    stat.firstPage = firstReg;
    stat.lastChunk = (remReg == chunkFull);
    stat.mergeOk   = contig && sameWin;
    stat.remZero   = (remReg == '0);
    stat.pendValid = pendValid;
    stat.capHit    = (entCnt == ENT_W'(MAX_ENT - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offReg    <= '0;
      remReg    <= '0;
      firstReg  <= 1'b0;
      openBase  <= '0;
      openCnt   <= '0;
      pendBase  <= '0;
      pendCnt   <= '0;
      pendValid <= 1'b0;
      entCnt    <= '0;
    end else begin
      if (ctl.latchReq) begin
        offReg    <= startOffset;
        remReg    <= totalLen;
        firstReg  <= 1'b1;
        pendValid <= 1'b0;
        entCnt    <= '0;
      end
      if (ctl.takePage) begin
        remReg   <= remReg - chunkFull;
        firstReg <= 1'b0;
        if (firstReg) begin
          openBase <= pageAddr + 32'(offReg);
          openCnt  <= chunk;
        end else if (contig && sameWin) begin
          openCnt <= openCnt + chunk;
        end else begin
          pendBase  <= pageAddr;
          pendCnt   <= chunk;
          pendValid <= 1'b1;
        end
      end
      if (ctl.emitCnt) begin
        entCnt <= entCnt + ENT_W'(1);
      end
      if (ctl.promote) begin
        openBase  <= pendBase;
        openCnt   <= pendCnt;
        pendValid <= 1'b0;
      end
    end
  end

  assign memAddr    = {entCnt, ctl.emitCnt};
  assign memData    = ctl.emitBase ? openBase
                                   : {~pendValid, 15'd0, openCnt[WIN_BITS-1:0]};
  assign entryCount = entCnt;

endmodule

// File: rtl/sgtCtrl.sv
module sgtCtrl
  import sgt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     lenZero,
  input  logic     pageAck,
  input  sgtStat_t stat,
  output sgtCtl_t  ctl,
  output logic     pageReq,
  output logic     memWe,
  output logic     doneP,
  output logic     doneErr,
  output logic     running
);

  sgtState_t state;
  sgtState_t nxt;
  logic      finOk;
  logic      finErr;

  always_comb begin
    ctl     = '0;
    pageReq = 1'b0;
    memWe   = 1'b0;
    finOk   = 1'b0;
    finErr  = 1'b0;
    nxt     = state;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          ctl.latchReq = 1'b1;
          if (lenZero) finErr = 1'b1;
          else         nxt    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        pageReq = 1'b1;
        if (pageAck) begin
          ctl.takePage = 1'b1;
          if (stat.firstPage || stat.mergeOk)
            nxt = stat.lastChunk ? ST_WBASE : ST_FETCH;
          else
            nxt = ST_WBASE;
        end
      end
      ST_WBASE: begin
        memWe        = 1'b1;
        ctl.emitBase = 1'b1;
        nxt          = ST_WCNT;
      end
      ST_WCNT: begin
        memWe       = 1'b1;
        ctl.emitCnt = 1'b1;
        if (!stat.pendValid) begin
          finOk = 1'b1;
          nxt   = ST_IDLE;
        end else if (stat.capHit) begin
          finErr = 1'b1;
          nxt    = ST_IDLE;
        end else begin
          ctl.promote = 1'b1;
          nxt = stat.remZero ? ST_WBASE : ST_FETCH;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneP   <= 1'b0;
      doneErr <= 1'b0;
    end else begin
      state   <= nxt;
      doneP   <= finOk | finErr;
      doneErr <= finErr;
    end
  end

  assign running = (state != ST_IDLE);

endmodule

// File: rtl/sgtBuilder.sv
module sgtBuilder
  import sgt_pkg::*;
#(
  parameter int PAGE_SIZE      = 4096,
  parameter int LEN_W          = 32,
  parameter int XFER_MAX_BYTES = 256 * 512,
  localparam int OFF_W   = $clog2(PAGE_SIZE),
  localparam int MAX_ENT = XFER_MAX_BYTES / PAGE_SIZE + 1,
  localparam int ENT_W   = $clog2(MAX_ENT + 1),
  localparam int WADDR_W = ENT_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [OFF_W-1:0]   startOffset,
  input  logic [LEN_W-1:0]   totalLen,
  output logic               pageReq,
  input  logic               pageAck,
  input  logic [31:0]        pageAddr,
  output logic               memWe,
  output logic [WADDR_W-1:0] memAddr,
  output logic [31:0]        memData,
  output logic               doneP,
  output logic               doneErr,
  output logic [ENT_W-1:0]   entryCount
);

  sgtCtl_t  ctl;
  sgtStat_t stat;
  logic     running;
  logic     lenZero;

  assign lenZero = (totalLen == '0);

  sgtCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .lenZero  (lenZero),
    .pageAck  (pageAck),
    .stat     (stat),
    .ctl      (ctl),
    .pageReq  (pageReq),
    .memWe    (memWe),
    .doneP    (doneP),
    .doneErr  (doneErr),
    .running  (running)
  );

  sgtPath #(
    .PAGE_SIZE (PAGE_SIZE),
    .LEN_W     (LEN_W),
    .OFF_W     (OFF_W),
    .MAX_ENT   (MAX_ENT),
    .ENT_W     (ENT_W),
    .WADDR_W   (WADDR_W)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .startOffset (startOffset),
    .totalLen    (totalLen),
    .pageAddr    (pageAddr),
    .stat        (stat),
    .memAddr     (memAddr),
    .memData     (memData),
    .entryCount  (entryCount)
  );

endmodule

// File: rtl/sgtChecker.sv
module sgtChecker #(
  parameter int LEN_W   = 32,
  parameter int MAX_ENT = 33,
  parameter int ENT_W   = 6,
  parameter int WADDR_W = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               startReq,
  input logic [LEN_W-1:0]   totalLen,
  input logic               running,
  input logic               pageReq,
  input logic               memWe,
  input logic [WADDR_W-1:0] memAddr,
  input logic [31:0]        memData,
  input logic               doneP,
  input logic               doneErr,
  input logic [ENT_W-1:0]   entryCount
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP); // R10

  AST_ZERO_LEN_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !running && totalLen == '0) |=> (doneP && doneErr)); // R9

  AST_WORD_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !memAddr[0]) |=>
      (memWe && memAddr[0] && memAddr[WADDR_W-1:1] == $past(memAddr[WADDR_W-1:1]))); // R7

  AST_END_THEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memAddr[0] && memData[31]) |=> (doneP && !doneErr)); // R5

  AST_CNT_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memAddr[0]) |-> (memData[30:16] == 15'd0)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (int'(memAddr) < 2 * MAX_ENT)); // R8

  AST_CAP_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (doneP && doneErr && entryCount != '0) |-> (int'(entryCount) == MAX_ENT)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!pageReq && !memWe)); // R12

endmodule

bind sgtBuilder sgtChecker #(
  .LEN_W   (LEN_W),
  .MAX_ENT (MAX_ENT),
  .ENT_W   (ENT_W),
  .WADDR_W (WADDR_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .totalLen   (totalLen),
  .running    (running),
  .pageReq    (pageReq),
  .memWe      (memWe),
  .memAddr    (memAddr),
  .memData    (memData),
  .doneP      (doneP),
  .doneErr    (doneErr),
  .entryCount (entryCount)
);

// File: tb/sgtBuilder_tb.sv
`timescale 1ns/1ps
module sgtBuilder_tb;

  localparam int PAGE = 4096;
  localparam int MAXE = 33;
  localparam int NV   = 10;

  // stimulus table: offset, length, first frame, frame stride, hop period
  localparam logic [31:0] V_OFF[NV]    = '{32'h0, 32'h100, 32'h800, 32'h0, 32'h200,
                                           32'h0, 32'hFFF, 32'hFFF, 32'h10, 32'h0};
  localparam logic [31:0] V_LEN[NV]    = '{32'h200, 32'h3000, 32'h2800, 32'h8000, 32'h7000,
                                           32'h10000, 32'h2, 32'h2, 32'h10000, 32'h21000};
  localparam logic [31:0] V_BASE[NV]   = '{32'h0010_0000, 32'h0020_0000, 32'h0030_0000,
                                           32'h0001_C000, 32'h0040_0000, 32'h0050_0000,
                                           32'h0070_0000, 32'h0071_0000, 32'h0060_0000,
                                           32'h0080_0000};
  localparam logic [31:0] V_STRIDE[NV] = '{32'h1000, 32'h1000, 32'h2000, 32'h1000, 32'h1000,
                                           32'h1000, 32'h1000, 32'h2000, 32'h1000, 32'h2000};
  localparam int          V_HOP[NV]    = '{0, 0, 0, 0, 3, 0, 0, 0, 0, 0};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [11:0] startOffset = '0;
  logic [31:0] totalLen = '0;
  logic        pageReq;
  logic        pageAck;
  logic [31:0] pageAddr;
  logic        memWe;
  logic [6:0]  memAddr;
  logic [31:0] memData;
  logic        doneP;
  logic        doneErr;
  logic [5:0]  entryCount;

  always #10 clk = ~clk;

  sgtBuilder u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startOffset(startOffset),
    .totalLen(totalLen), .pageReq(pageReq), .pageAck(pageAck), .pageAddr(pageAddr),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .doneP(doneP),
    .doneErr(doneErr), .entryCount(entryCount)
  );

  int nChecks = 0;
  int nFails  = 0;

  // page lookup model
  logic [31:0] curBase, curStride;
  int          curHop;
  int          pageIdx;
  logic        ackEn = 1'b1;
  logic [7:0]  lfsr = 8'hA5;

  function automatic logic [31:0] frameOf(int i);
    logic [31:0] f;
    f = curBase + 32'(i) * curStride;
    if (curHop > 0 && (i % curHop) == curHop - 1) f = f + 32'h0100_0000;
    return f;
  endfunction

  assign pageAck  = pageReq && ackEn;
  always_comb pageAddr = frameOf(pageIdx);

  always @(negedge clk) begin
    lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ackEn <= lfsr[0] | lfsr[2];
  end

  // capture of table writes and completions
  logic [31:0] mem [128];
  int   wrCount, pageCount, doneCnt;
  logic gotErr;
  logic [5:0] gotCount;
  logic clrReq = 1'b0;

  always @(posedge clk) begin
    if (clrReq) begin
      for (int i = 0; i < 128; i++) mem[i] <= 32'hDEAD_BEEF;
      wrCount <= 0; pageCount <= 0; doneCnt <= 0; pageIdx <= 0;
      gotErr <= 1'b0; gotCount <= '0;
    end else begin
      if (memWe) begin
        mem[memAddr] <= memData;
        wrCount <= wrCount + 1;
      end
      if (pageReq && pageAck) begin
        pageIdx   <= pageIdx + 1;
        pageCount <= pageCount + 1;
      end
      if (doneP) begin
        doneCnt  <= doneCnt + 1;
        gotErr   <= doneErr;
        gotCount <= entryCount;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected table
  logic [31:0] expBase [64];
  int          expCnt  [64];
  int          expN, expPages;
  bit          expErr;

  task automatic computeExp(input int off, input int len);
    longint pb, pc, nb, nc, rem;
    int i;
    expN = 0; expErr = 0;
    if (len == 0) begin expErr = 1; expPages = 0; return; end
    pb  = longint'(frameOf(0)) + off;
    pc  = (len < PAGE - off) ? len : PAGE - off;
    rem = len - pc;
    i   = 1;
    while (rem > 0) begin
      nb = longint'(frameOf(i));
      nc = (rem < PAGE) ? rem : PAGE;
      if ((pb + pc == nb) && (((nb + nc - 1) >> 16) == (pb >> 16))) begin
        pc = pc + nc;
      end else begin
        expBase[expN] = 32'(pb); expCnt[expN] = int'(pc); expN++;
        if (expN >= MAXE) begin expErr = 1; break; end
        pb = nb; pc = nc;
      end
      rem = rem - nc;
      i++;
    end
    if (!expErr) begin
      expBase[expN] = 32'(pb); expCnt[expN] = int'(pc); expN++;
    end
    expPages = i;
  endtask

  task automatic clearCapture();
    @(negedge clk); clrReq = 1'b1;
    @(negedge clk); clrReq = 1'b0;
  endtask

  task automatic waitDone(input int limit);
    int n = 0;
    while (doneCnt == 0 && n < limit) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk(doneCnt == 1, "R10", "done pulse count", doneCnt, 1);
  endtask

  task automatic runXfer(input int off, input int len, input logic [31:0] base,
                         input logic [31:0] stride, input int hop, input string tag);
    logic [31:0] w;
    curBase = base; curStride = stride; curHop = hop;
    clearCapture();
    computeExp(off, len);
    @(negedge clk);
    startOffset = 12'(off); totalLen = 32'(len); startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitDone(4000);
    chk(gotErr == expErr, "R10", {tag, " error flag"}, gotErr, expErr);
    chk(int'(gotCount) == expN, "R10", {tag, " entry count"}, gotCount, expN);
    chk(wrCount == 2 * expN, "R7", {tag, " word writes"}, wrCount, 2 * expN);
    if (!expErr)
      chk(pageCount == expPages, "R2", {tag, " page lookups"}, pageCount, expPages);
    for (int k = 0; k < expN; k++) begin
      w = {(k == expN - 1) && !expErr, 15'd0, 16'(expCnt[k])};
      chk(mem[2*k] == expBase[k], (k == 0) ? "R1" : "R3/R4", {tag, " base word"},
          mem[2*k], expBase[k]);
      chk(mem[2*k+1] == w, "R5", {tag, " count word"}, mem[2*k+1], w);
    end
  endtask

  initial begin
    #(20 * 190000);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    curBase = 32'h0; curStride = 32'h1000; curHop = 0;
    clearCapture();
    repeat (3) @(negedge clk);
    // R12: quiet during reset
    chk(!pageReq && !memWe && !doneP, "R12", "outputs in reset",
        {pageReq, memWe, doneP}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!pageReq && !memWe && !doneP && entryCount == 0, "R12", "idle after reset",
        {pageReq, memWe, doneP, entryCount}, 0);

    for (int v = 0; v < NV; v++)
      runXfer(int'(V_OFF[v]), int'(V_LEN[v]), V_BASE[v], V_STRIDE[v], V_HOP[v],
              $sformatf("vec%0d", v));

    // R6: a full 64 KiB descriptor stores zero in its count field
    runXfer(0, 32'h10000, 32'h0050_0000, 32'h1000, 0, "r6_full");
    chk(mem[1] == 32'h8000_0000, "R6", "65536 byte count word", mem[1], 32'h8000_0000);

    // R3: contiguous pages split at a 64 KiB window edge
    runXfer(0, 32'h8000, 32'h0001_C000, 32'h1000, 0, "r3_win");
    chk(mem[2] == 32'h0002_0000, "R3", "second base at window", mem[2], 32'h0002_0000);

    // R8: one descriptor too many
    runXfer(0, 34 * PAGE, 32'h0090_0000, 32'h2000, 0, "r8_cap");
    chk(gotErr == 1'b1 && gotCount == 6'(MAXE), "R8", "cap error",
        {gotErr, gotCount}, {1'b1, 6'(MAXE)});

    // R9: zero length
    runXfer(0, 0, 32'h00A0_0000, 32'h1000, 0, "r9_zero");
    chk(wrCount == 0 && pageCount == 0, "R9", "no activity",
        wrCount + pageCount, 0);

    // R11: second start while busy is ignored
    curBase = 32'h00B0_0000; curStride = 32'h2000; curHop = 0;
    clearCapture();
    computeExp(0, 3 * PAGE);
    @(negedge clk);
    startOffset = 12'h0; totalLen = 3 * PAGE; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (2) @(negedge clk);
    totalLen = 32'h0; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0; totalLen = 3 * PAGE;
    waitDone(4000);
    chk(gotErr == 1'b0 && int'(gotCount) == expN, "R11", "busy start ignored",
        {gotErr, gotCount}, expN);
    chk(mem[5] == {1'b1, 15'd0, 16'h1000}, "R11", "last entry intact",
        mem[5], {1'b1, 15'd0, 16'h1000});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule